// File: doc/BRIEF.md
# Buffered Dual-Channel PWM Timer

This block is a 16-bit up-counter with a programmable period and a power-of-two clock divider. It drives two compare channels whose outputs are PWM pin levels. Each channel can run on its own as an unbuffered PWM. Channel 0 can instead claim both compare registers as a pair. In that case the register it compares against alternates at every counter wrap, so software can load the next pulse width into the idle register without a glitch on the pin.

Software programs the block through a plain write port with six word addresses:

| Address | Contents |
|---|---|
| 0 | Control: halt in bit 0, counter/divider clear strobe in bit 1, divider select in bits 4:2 |
| 1 | Period limit |
| 2 | Compare register 0 |
| 3 | Compare register 1 |
| 4 | Channel 0 setup |
| 5 | Channel 1 setup |

Software sets halt while it configures the block, then writes the control word with halt cleared and clear set to start PWM output. The block raises an overflow flag for one cycle at every counter wrap.

Each channel setup word holds three fields:

- Mode in bits 1:0: 01 is single, 10 is paired (channel 0 only), any other value disables the channel.
- Toggle-at-wrap in bit 2.
- Compare action in bits 4:3: 10 drives the pin low, 11 drives it high, and 00 or 01 take no action.

A toggle on compare is deliberately not offered.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset both pins and the overflow flag are low, and the timer is halted, so no overflow pulse appears until software starts it.
- R2: While the halt bit (control bit 0) is 1, neither the divider nor the counter advances, no overflow pulse occurs and the pins hold their level.
- R3: Writing control bit 1 as 1 clears the counter and the divider in that cycle. With halt 0, the first overflow pulse is seen (M+1)·2^S cycles after the clear, for period limit M and divider select S.
- R4: The counter runs 0..M and wraps to 0. The overflow flag is high for exactly the one cycle after each wrap, so successive pulses are (M+1)·2^S cycles apart.
- R5: Divider select S (control bits 4:2) divides by 2^S for S in 0..6. The value 7 behaves as 6.
- R6: For a single channel with toggle-at-wrap 1 and action 10 (clear), a compare value K with 0 ≤ K ≤ M gives a high time of K·2^S cycles per period. K = 0 gives a constant low level, because compare wins over toggle on the same tick.
- R7: With action 11 (set) and toggle-at-wrap 1, the low time is K·2^S cycles per period, and K = 0 gives a constant high level.
- R8: A compare value above M produces no compare event, so the pin changes only by the toggle at each wrap.
- R9: With channel 0 mode 10 (paired), channel 0 uses compare registers 0 and 1 in alternate periods, switching at each wrap. The channel 1 pin stays low whatever its own setup.
- R10: In paired mode, a write to the register not used in the running period changes nothing in that period and takes effect in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Channel 0 pin (paired output in paired mode) |
| pwm_b | output | 1 | Channel 1 pin |
| ovf | output | 1 | One-cycle pulse after each counter wrap |

## Verification
The bench sweeps every compare value from 0 to one above the period limit, under three divider settings and both compare polarities. It measures pin high time over two whole periods against the arithmetic expectation.

These sweeps catch the main failure modes:

- A design that let the wrap toggle beat a coincident compare would miss the 0% and 100% levels.
- An off-by-one in the compare or wrap point would shift every duty count.
- A divider misdecode, including the clamped select value, shows up in the measured period and in the clear-to-first-overflow latency.

For paired mode, the bench confirms alternating high times. It then rewrites the idle register at the start of a period. A design that switched registers at the wrong time, or read the idle register too early, would change the running period instead of the next one.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIM  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG0 = 3'd4;
  localparam logic [ADDR_W-1:0] A_CFG1 = 3'd5;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_PAIR   = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_RSVD = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } act_e;

  // Setup word layout: [4:3] action, [2] toggle at wrap, [1:0] mode
  typedef struct packed {
    act_e  act;
    logic  tov;
    mode_e mode;
  } chcfg_t;

  localparam int CFG_W = $bits(chcfg_t);
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [SEL_W-1:0] eff_sel;
  logic [DIV_W-1:0] mask;

  always_comb begin
    eff_sel = (int'(sel) > DIV_W) ? SEL_W'(DIV_W) : sel;
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(eff_sel));
    end
    tick = run && ((div_q & mask) == mask);
  end

  always_comb begin
    if (clr)      div_d = '0;
    else if (run) div_d = div_q + 1'b1;
    else          div_d = div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(div_q));

  // R3
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (div_q == '0));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic [W-1:0] evt_val,
  output logic         wrap,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;

  always_comb begin
    wrap    = tick && (cnt_q >= limit);
    evt_val = wrap ? '0 : cnt_q + 1'b1;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = evt_val;
    else           cnt_d = cnt_q;
    ovf_d = wrap && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign ovf = ovf_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));

  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R4
  ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] evt_val,
  input  logic [W-1:0] cmp,
  input  act_e         act,
  input  logic         tov,
  output logic         pin
);
  logic pin_q, pin_d;
  logic hit;

  always_comb begin
    hit = tick && (evt_val == cmp);
    if (!en)                   pin_d = 1'b0;
    else if (hit && act[1])    pin_d = act[0];
    else if (wrap && tov)      pin_d = !pin_q;
    else                       pin_d = pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

  // R6
  cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit && act == ACT_LOW) |=> !pin_q);

  // R7
  cmp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit && act == ACT_HIGH) |=> pin_q);

  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pin_q);

  // R2
  pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(pin_q));
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwm_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 6,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              ovf
);
  localparam int NCH = 2;

  logic rst_s0, rst_s1, rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_i = rst_s1;

  logic             halt_q, halt_d;
  logic [SEL_W-1:0] psel_q, psel_d;
  logic [W-1:0]     lim_q, lim_d;
  logic [W-1:0]     cmp_q [NCH];
  logic [W-1:0]     cmp_d [NCH];
  chcfg_t           cfg_q [NCH];
  chcfg_t           cfg_d [NCH];
  logic             sel_q, sel_d;

  logic         clr_stb, tick, wrap, pair, sel_now;
  logic [W-1:0] evt_val;
  logic         pin [NCH];

  assign clr_stb = wr_en && (wr_addr == A_CTRL) && wr_data[1];
  assign pair    = (cfg_q[0].mode == MODE_PAIR);

  always_comb begin
    halt_d = halt_q;
    psel_d = psel_q;
    lim_d  = lim_q;
    for (int c = 0; c < NCH; c++) begin
      cmp_d[c] = cmp_q[c];
      cfg_d[c] = cfg_q[c];
    end
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          halt_d = wr_data[0];
          psel_d = wr_data[2 +: SEL_W];
        end
        A_LIM:  lim_d    = wr_data;
        A_CMP0: cmp_d[0] = wr_data;
        A_CMP1: cmp_d[1] = wr_data;
        A_CFG0: cfg_d[0] = chcfg_t'(wr_data[CFG_W-1:0]);
        A_CFG1: cfg_d[1] = chcfg_t'(wr_data[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    sel_now = wrap ? !sel_q : sel_q;
    if (clr_stb || !pair) sel_d = 1'b0;
    else                  sel_d = sel_now;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      halt_q <= 1'b1;
      psel_q <= '0;
      lim_q  <= '1;
      sel_q  <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        cmp_q[c] <= '1;
        cfg_q[c] <= '0;
      end
    end else begin
      halt_q <= halt_d;
      psel_q <= psel_d;
      lim_q  <= lim_d;
      sel_q  <= sel_d;
      for (int c = 0; c < NCH; c++) begin
        cmp_q[c] <= cmp_d[c];
        cfg_q[c] <= cfg_d[c];
      end
    end
  end

  pwm_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
    .clk  (clk),
    .rst_n(rst_i),
    .run  (!halt_q),
    .clr  (clr_stb),
    .sel  (psel_q),
    .tick (tick)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_i),
    .tick   (tick),
    .clr    (clr_stb),
    .limit  (lim_q),
    .evt_val(evt_val),
    .wrap   (wrap),
    .ovf    (ovf)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic         ch_en;
    logic [W-1:0] ch_cmp;
    if (c == 0) begin : g_lead
      assign ch_en  = (cfg_q[0].mode == MODE_SINGLE) || pair;
      assign ch_cmp = (pair && sel_now) ? cmp_q[1] : cmp_q[0];
    end else begin : g_follow
      assign ch_en  = !pair && (cfg_q[c].mode == MODE_SINGLE);
      assign ch_cmp = cmp_q[c];
    end
    pwm_channel #(.W(W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_i),
      .en     (ch_en),
      .tick   (tick),
      .wrap   (wrap),
      .evt_val(evt_val),
      .cmp    (ch_cmp),
      .act    (cfg_q[c].act),
      .tov    (cfg_q[c].tov),
      .pin    (pin[c])
    );
  end

  assign pwm_a = pin[0];
  assign pwm_b = pin[1];

  // R9
  pair_swap_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (pair && wrap && !clr_stb && !(wr_en && wr_addr == A_CFG0))
      |=> (sel_q != $past(sel_q)));

  // R9
  pair_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (pair && !wrap && !clr_stb && !(wr_en && wr_addr == A_CFG0))
      |=> $stable(sel_q));

  // R1
  halt_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (halt_q && !clr_stb) |=> !ovf);
endmodule

// File: tb/pwm_dual_timer_test.sv
module pwm_dual_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b, ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_dual_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .ovf(ovf)
  );

  localparam logic [15:0] CFG_SGL_LOW  = 16'h0015;
  localparam logic [15:0] CFG_SGL_HIGH = 16'h001D;
  localparam logic [15:0] CFG_PAIR_LOW = 16'h0016;
  localparam int LIM = 5;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ovf(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!ovf && n < 2000);
  endtask

  task automatic setup(input int s, input int lim, input int c0, input int c1,
                       input logic [15:0] g0, input logic [15:0] g1);
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'(lim));
    wr(3'd2, 16'(c0));
    wr(3'd3, 16'(c1));
    wr(3'd4, g0);
    wr(3'd5, g1);
    wr(3'd0, 16'((s << 2) | 2));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int n, hi, hib, p, exp_a, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state and halted start
    chk("R1 pwm_a", pwm_a, 0);
    chk("R1 pwm_b", pwm_b, 0);
    chk("R1 ovf", ovf, 0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin step(); cnt += ovf; end
    chk("R1 no overflow while halted", cnt, 0);

    // R6 R7 R8 R4: sweep divider, compare value and polarity
    for (int s = 0; s < 3; s++) begin
      p = 1 << s;
      for (int pol = 0; pol < 2; pol++) begin
        for (int k = 0; k <= LIM + 1; k++) begin
          setup(s, LIM, k, 3, pol ? CFG_SGL_HIGH : CFG_SGL_LOW, CFG_SGL_LOW);
          wait_ovf(n);
          wait_ovf(n);
          chk("R4 period", n, (LIM + 1) * p);
          hi = 0; hib = 0;
          for (int i = 0; i < 2 * (LIM + 1) * p; i++) begin
            hi += pwm_a; hib += pwm_b; step();
          end
          if (k > LIM)       exp_a = (LIM + 1) * p;
          else if (pol == 0) exp_a = 2 * k * p;
          else               exp_a = 2 * (LIM + 1 - k) * p;
          if (k > LIM)       chk("R8 toggle only", hi, exp_a);
          else if (pol == 0) chk("R6 clear polarity", hi, exp_a);
          else               chk("R7 set polarity", hi, exp_a);
          chk("R6 channel b", hib, 2 * 3 * p);
        end
      end
    end

    // R3 clear to first overflow latency, divider 4
    setup(2, LIM, 2, 3, CFG_SGL_LOW, CFG_SGL_LOW);
    wait_ovf(n);
    step(); step();
    wr(3'd0, 16'((2 << 2) | 2));
    n = 0;
    while (!ovf && n < 2000) begin step(); n++; end
    chk("R3 clear latency", n, (LIM + 1) * 4);

    // R2 halt while running
    wr(3'd0, 16'((2 << 2) | 1));
    hi = pwm_a; cnt = 0; hib = 0;
    for (int i = 0; i < 100; i++) begin
      step(); cnt += ovf; if (pwm_a != hi) hib++;
    end
    chk("R2 no overflow", cnt, 0);
    chk("R2 pin held", hib, 0);

    // R5 select 7 behaves as divide by 64
    setup(7, LIM, 2, 3, CFG_SGL_LOW, CFG_SGL_LOW);
    wait_ovf(n);
    wait_ovf(n);
    chk("R5 clamp period", n, (LIM + 1) * 64);

    // R9 R10 paired operation
    setup(0, LIM, 2, 4, CFG_PAIR_LOW, CFG_SGL_LOW);
    wait_ovf(n);
    wait_ovf(n);
    hi = 0; hib = 0;
    for (int i = 0; i < LIM + 1; i++) begin hi += pwm_a; hib += pwm_b; step(); end
    chk("R9 first period", (hi == 2 || hi == 4) ? 1 : 0, 1);
    chk("R9 ovf at next period", ovf, 1);
    wr_en = 1'b1; wr_addr = (hi == 2) ? 3'd2 : 3'd3; wr_data = 16'd1;
    cnt = 0;
    for (int i = 0; i < LIM + 1; i++) begin cnt += pwm_a; hib += pwm_b; step(); end
    chk("R9 alternate period", cnt, 6 - hi);
    chk("R10 idle write deferred", cnt, 6 - hi);
    cnt = 0;
    for (int i = 0; i < LIM + 1; i++) begin cnt += pwm_a; hib += pwm_b; step(); end
    chk("R10 idle write applied", cnt, 1);
    chk("R9 pwm_b low", hib, 0);

    done = 1'b1;
    summary();
  end
endmodule